// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that sits on a simple processor register bus. Software writes a byte to the data offset. The transmitter sends it on `txd` as one frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Between frames the line rests high. The receiver watches `rxd` at sixteen times the bit rate. It finds the high-to-low edge of a start bit, confirms that edge half a bit later, and then samples each following bit near its middle. It checks parity and the stop bit, then hands the byte to software through the same data offset.

The bus is a single-cycle register port. `bus_rdata` is combinational and valid in the cycle where `bus_sel` is high and `bus_wr` is low. A read or write takes effect at the clock edge that ends that cycle. Byte flow uses ready flags as its back-pressure. A write to the data offset is taken only while the transmit-ready flag is 1; a write made while it is 0 is dropped. A received byte waits until the data offset is read. If a newer byte arrives first, it replaces the waiting byte and the overrun flag is raised. One programmable divisor sets the number of system clocks per sixteenth of a bit. Transmitter and receiver share that divisor.

Top module: `serial_port_mm`

## Requirements
- R1: After reset `txd` is 1. Offset 0x18 reads 1, offset 0x14 reads 0, and offset 0x1C reads 27: a divisor of 27 with parity and two-stop off.
- R2: A write to offset 0x10 while ready sends bits 7:0 as a frame. The frame is a 0 start bit, then data bits 0 to 7 in order, then a 1 stop bit. Each bit lasts 16 ticks.
- R3: Offset 0x1C bit 16 enables a parity bit, sent after bit 7. Bit 17 selects odd parity: the count of ones in data plus parity is odd when bit 17 is 1 and even when it is 0.
- R4: When offset 0x1C bit 18 is 1, the transmitter sends two stop bits, and transmit-ready stays 0 until the second stop bit has ended.
- R5: Offset 0x18 bit 0 (transmit-ready) goes to 0 when a write is accepted and returns to 1 after the last stop bit. A write to 0x10 while it is 0 is dropped: nothing extra is sent.
- R6: Reading offset 0x10 returns the received byte in bits 7:0, with bits 31:8 at 0. Offset 0x14 bit 0 (receive-ready) goes to 1 when a byte is delivered and to 0 when offset 0x10 is read.
- R7: A low pulse on `rxd` that has ended by the eighth tick after it is detected is treated as a glitch: no byte is delivered.
- R8: A stop bit sampled as 0 sets offset 0x14 bit 1 (framing error). The byte is still delivered, and the receiver waits for the line to go high before it looks for a new start bit.
- R9: With parity enabled, a received parity bit that breaks the selected rule sets offset 0x14 bit 2.
- R10: A byte delivered while receive-ready is 1 sets offset 0x14 bit 3 (overrun) and replaces the stored byte. Reading offset 0x14 clears bits 3:1.
- R11: The transmitter and receiver run at the same time without affecting each other.
- R12: Offset 0x1C bits 15:0 set the number of system clocks per tick. One bit lasts 16 times that many clocks; a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rxd | input | 1 | Serial input line, asynchronous |
| txd | output | 1 | Serial output line |

## Verification
The hardest situation to reach from the ports is full-duplex activity: a byte arriving on `rxd` while the transmitter is mid-frame. The bench reaches it by forking a line driver for a receive frame alongside a register write and a mid-bit capture of `txd`, then checking both bytes. Glitch rejection and framing errors also need exact line timing. The bench produces them by driving a start pulse only two ticks long, and by holding the stop bit low for a full bit before releasing the line. A second divisor value confirms that bit length scales with the divisor.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BREAK
  } ser_state_e;

  typedef struct packed {
    logic two_stop;
    logic par_odd;
    logic par_en;
  } line_cfg_t;

  localparam logic [5:0] OFS_DATA   = 6'h10;
  localparam logic [5:0] OFS_RXSTAT = 6'h14;
  localparam logic [5:0] OFS_TXSTAT = 6'h18;
  localparam logic [5:0] OFS_CFG    = 6'h1C;
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (div <= 1) || (cnt >= div - 1'b1);
  assign tick = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1 && $stable(div)) |=> (!tick || div <= 1)); // R12
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import serial_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_cfg_t  cfg,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       txd,
  output logic       ready
);
  ser_state_e state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       par_bit;
  line_cfg_t  cfg_q;

  assign ready = (state == S_IDLE);

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_PAR:   txd = par_bit;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0;
      par_bit <= 1'b0; cfg_q <= '0;
    end else if (state == S_IDLE) begin
      if (load) begin
        sh      <= load_data;
        par_bit <= (^load_data) ^ cfg.par_odd;
        cfg_q   <= cfg;
        tcnt    <= '0;
        bidx    <= '0;
        state   <= S_START;
      end
    end else if (tick) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == 4'd15) begin
        case (state)
          S_START: state <= S_DATA;
          S_DATA: begin
            sh   <= sh >> 1;
            bidx <= bidx + 1'b1;
            if (bidx == 3'd7) state <= cfg_q.par_en ? S_PAR : S_STOP1;
          end
          S_PAR:   state <= S_STOP1;
          S_STOP1: state <= cfg_q.two_stop ? S_STOP2 : S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load) |=> !ready); // R5
  AST_FRAME_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> !ready); // R2
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import serial_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  line_cfg_t  cfg,
  input  logic       line,
  input  logic       rd_data,
  input  logic       rd_stat,
  output logic [7:0] byte_q,
  output logic       ready,
  output logic       ferr,
  output logic       perr,
  output logic       ovr
);
  ser_state_e state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       par_bit;
  line_cfg_t  cfg_q;
  logic       deliver;
  logic       par_bad;

  assign deliver = (state == S_STOP1) && tick && (tcnt == 4'd15);
  assign par_bad = cfg_q.par_en && (((^sh) ^ par_bit) != cfg_q.par_odd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0;
      par_bit <= 1'b0; cfg_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (tick && !line) begin
          tcnt  <= '0;
          cfg_q <= cfg;
          state <= S_START;
        end
        S_START: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            state <= line ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd15) begin
            sh   <= {line, sh[7:1]};
            bidx <= bidx + 1'b1;
            if (bidx == 3'd7) state <= cfg_q.par_en ? S_PAR : S_STOP1;
          end
        end
        S_PAR: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd15) begin
            par_bit <= line;
            state   <= S_STOP1;
          end
        end
        S_STOP1: if (tick) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == 4'd15) state <= line ? S_IDLE : S_BREAK;
        end
        default: if (line) state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0; ready <= 1'b0; ferr <= 1'b0; perr <= 1'b0; ovr <= 1'b0;
    end else if (deliver) begin
      byte_q <= sh;
      ready  <= 1'b1;
      ferr   <= (ferr && !rd_stat) || !line;
      perr   <= (perr && !rd_stat) || par_bad;
      ovr    <= (ovr && !rd_stat) || ready;
    end else begin
      if (rd_data) ready <= 1'b0;
      if (rd_stat) begin
        ferr <= 1'b0; perr <= 1'b0; ovr <= 1'b0;
      end
    end
  end

  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !deliver) |=> !ready); // R6
  AST_DELIVER_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> ready); // R6
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && ready) |=> ovr); // R10
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !deliver) |=> !(ferr || perr || ovr)); // R10
endmodule

// File: rtl/serial_port_mm.sv
module serial_port_mm
  import serial_port_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int DEF_DIV = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxd,
  output logic              txd
);
  localparam int CFG_W = DIV_W + 3;

  logic [DIV_W-1:0] div_q;
  line_cfg_t        cfg_q;
  logic [1:0]       rx_sync;
  logic             tick, wr, rd;
  logic             tx_ready, rx_ready, rx_ferr, rx_perr, rx_ovr;
  logic [7:0]       rx_byte;

  assign wr = bus_sel && bus_wr;
  assign rd = bus_sel && !bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DEF_DIV);
      cfg_q   <= '0;
      rx_sync <= 2'b11;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (wr && bus_addr == OFS_CFG) begin
        div_q <= bus_wdata[DIV_W-1:0];
        cfg_q <= bus_wdata[CFG_W-1:DIV_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA:   bus_rdata[7:0] = rx_byte;
      OFS_RXSTAT: bus_rdata[3:0] = {rx_ovr, rx_perr, rx_ferr, rx_ready};
      OFS_TXSTAT: bus_rdata[0]   = tx_ready;
      OFS_CFG:    bus_rdata[CFG_W-1:0] = {cfg_q, div_q};
      default:    bus_rdata = '0;
    endcase
  end

  sp_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

  sp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg_q),
    .load(wr && bus_addr == OFS_DATA), .load_data(bus_wdata[7:0]),
    .txd(txd), .ready(tx_ready));

  sp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg_q), .line(rx_sync[1]),
    .rd_data(rd && bus_addr == OFS_DATA), .rd_stat(rd && bus_addr == OFS_RXSTAT),
    .byte_q(rx_byte), .ready(rx_ready), .ferr(rx_ferr), .perr(rx_perr),
    .ovr(rx_ovr));

  AST_TX_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && wr && bus_addr == OFS_DATA) |=> $stable(txd) || !tick); // R5
endmodule

// File: tb/serial_port_mm_test.sv
module serial_port_mm_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rxd = 1, txd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  serial_port_mm uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic set_cfg(input bit two, input bit odd, input bit en, input int dv);
    bus_write(6'h1C, {13'd0, two, odd, en, dv[15:0]});
  endtask

  task automatic send_rx(input logic [7:0] d, input bit en, input bit odd,
                         input bit bad_par, input bit bad_stop, input int bitc);
    @(negedge clk); rxd = 0; repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bitc) @(negedge clk); end
    if (en) begin rxd = (^d) ^ odd ^ bad_par; repeat (bitc) @(negedge clk); end
    rxd = !bad_stop; repeat (bitc) @(negedge clk);
    rxd = 1;
  endtask

  function automatic logic [11:0] frame(input logic [7:0] d, input bit en,
                                         input bit odd, input bit two);
    logic [11:0] f = '1;
    f[0] = 0; f[8:1] = d;
    if (en) f[9] = (^d) ^ odd;
    return f;
  endfunction

  task automatic capture_tx(input int nb, input int bitc, output logic [11:0] b);
    b = '1;
    while (txd) @(negedge clk);
    repeat (bitc / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      b[i] = txd;
      if (i != nb - 1) repeat (bitc) @(negedge clk);
    end
  endtask

  task automatic tx_case(input logic [7:0] d, input bit en, input bit odd,
                         input bit two, input int bitc, input string req);
    logic [11:0] got, exp;
    logic [31:0] r;
    int nb = 10 + int'(en) + int'(two);
    exp = frame(d, en, odd, two);
    bus_write(6'h10, {24'd0, d});
    bus_read(6'h18, r);
    chk(r == 0, {req, " R5 busy after write"}, r, 0);
    bus_write(6'h10, 32'h000000FF);
    capture_tx(nb, bitc, got);
    chk(got == exp, {req, " frame bits"}, 32'(got), 32'(exp));
    bus_read(6'h18, r);
    chk(r == 0, {req, " R5/R4 busy in last stop bit"}, r, 0);
    repeat (bitc) @(negedge clk);
    bus_read(6'h18, r);
    chk(r == 1, {req, " R5 ready after frame"}, r, 1);
    repeat (2 * bitc) @(negedge clk);
    chk(txd == 1, {req, " R5 dropped write sends nothing"}, 32'(txd), 1);
  endtask

  task automatic rx_expect(input logic [31:0] stat, input logic [7:0] d,
                           input string req);
    logic [31:0] r;
    bus_read(6'h14, r);
    chk(r == stat, {req, " status"}, r, stat);
    bus_read(6'h10, r);
    chk(r == {24'd0, d}, {req, " data"}, r, {24'd0, d});
    bus_read(6'h14, r);
    chk(r == 0, {req, " status after reads"}, r, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [11:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1, "R1 txd idle", 32'(txd), 1);
    bus_read(6'h18, r); chk(r == 1, "R1 tx status", r, 1);
    bus_read(6'h14, r); chk(r == 0, "R1 rx status", r, 0);
    bus_read(6'h1C, r); chk(r == 27, "R1 config", r, 27);

    // R12 divisor readback and timing at 3 clocks per tick
    set_cfg(0, 0, 0, 3);
    bus_read(6'h1C, r); chk(r == 3, "R12 config readback", r, 3);
    tx_case(8'hA5, 0, 0, 0, 48, "R2");
    tx_case(8'h01, 0, 0, 0, 48, "R2 low byte");
    set_cfg(0, 0, 1, 3);
    tx_case(8'h37, 1, 0, 0, 48, "R3 even");
    set_cfg(0, 1, 1, 3);
    tx_case(8'h37, 1, 1, 0, 48, "R3 odd");
    set_cfg(1, 0, 0, 3);
    tx_case(8'hC4, 0, 0, 1, 48, "R4 two stop");
    set_cfg(0, 0, 0, 5);
    tx_case(8'h5A, 0, 0, 0, 80, "R12 divisor 5");

    // R6 receive
    set_cfg(0, 0, 0, 3);
    send_rx(8'h9E, 0, 0, 0, 0, 48);
    rx_expect(32'h1, 8'h9E, "R6 receive");
    send_rx(8'h00, 0, 0, 0, 0, 48);
    rx_expect(32'h1, 8'h00, "R6 zero byte");

    // R7 glitch: low for two ticks only
    @(negedge clk); rxd = 0; repeat (6) @(negedge clk); rxd = 1;
    repeat (96) @(negedge clk);
    bus_read(6'h14, r); chk(r == 0, "R7 glitch rejected", r, 0);
    send_rx(8'h42, 0, 0, 0, 0, 48);
    rx_expect(32'h1, 8'h42, "R7 frame after glitch");

    // R8 framing error
    send_rx(8'h81, 0, 0, 0, 1, 48);
    repeat (48) @(negedge clk);
    rx_expect(32'h3, 8'h81, "R8 framing");

    // R9 parity error, and a good parity frame
    set_cfg(0, 0, 1, 3);
    send_rx(8'h6B, 1, 0, 1, 0, 48);
    rx_expect(32'h5, 8'h6B, "R9 parity error");
    set_cfg(0, 1, 1, 3);
    send_rx(8'h6B, 1, 1, 0, 0, 48);
    rx_expect(32'h1, 8'h6B, "R9 odd parity ok");

    // R10 overrun
    set_cfg(0, 0, 0, 3);
    send_rx(8'h11, 0, 0, 0, 0, 48);
    send_rx(8'h22, 0, 0, 0, 0, 48);
    rx_expect(32'h9, 8'h22, "R10 overrun");

    // R11 full duplex
    fork
      send_rx(8'h3C, 0, 0, 0, 0, 48);
      begin
        bus_write(6'h10, 32'h96);
        capture_tx(10, 48, got);
        chk(got == frame(8'h96, 0, 0, 0), "R11 tx during rx", 32'(got),
            32'(frame(8'h96, 0, 0, 0)));
      end
    join
    repeat (48) @(negedge clk);
    rx_expect(32'h1, 8'h3C, "R11 rx during tx");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule